// File: doc/BRIEF.md
# Byte-Oriented Register ALU with Skip

This block is the execute stage of an 8-bit accumulator machine whose instructions are 16 bits wide. Each instruction word carries an operation in its upper byte and a file-register address in its lower byte. The stage takes the operand already read from the register file at that address, the working register (W) and the current status flags. It combines them and returns write enables and data for the file register, for W and for each flag.

Conditional instructions test a value and can discard the next instruction. The pipeline has already fetched that instruction. When the test is true, the stage raises a one-cycle skip request and turns the next valid instruction it receives into a no-operation. A skipping instruction therefore costs one extra cycle only when its condition holds.

Fetch, register-file storage and flag storage stay outside the block. The stage keeps a single bit of state of its own: the pending squash.

Top module: `regalu_exec`

## Requirements
- R1: Reset clears any pending squash. The first valid instruction after reset executes normally. While `instrValid` is low, every write enable, `skipReq` and `unsupported` are 0.
- R2: Flag vector layout is bit0 C, bit1 DC, bit2 Z, bit3 OV. Add (high byte 0x0E/0x0F) computes f+W. Add-with-carry (0x10/0x11) computes f+W+C. Both write all four flags. C is the carry out of bit 7 and DC is the carry out of bit 3. OV is signed overflow and Z means an 8-bit result of zero.
- R3: Subtract (0x04/0x05) computes f−W. Subtract-with-borrow (0x02/0x03) computes f−W−(1−C). Both write all four flags, with C=1 meaning no borrow and DC=1 meaning no borrow out of the low nibble.
- R4: Increment (0x14/0x15) computes f+1 and decrement (0x06/0x07) computes f−1. Both write all four flags with the add and subtract conventions of R2 and R3.
- R5: AND (0x0A/0x0B) computes f&W, inclusive OR (0x08/0x09) computes f|W and complement (0x12/0x13) computes ~f. These three write only Z.
- R6: Rotate left through carry (0x1A/0x1B) and rotate right through carry (0x18/0x19) write only C, which takes the bit shifted out. Rotate left (0x22/0x23), rotate right (0x20/0x21) and nibble swap (0x1C/0x1D) write no flag.
- R7: Bit 8 (d) selects the destination for d-form operations: 0 writes W and 1 writes the file register. `fileAddr` always equals bits 7:0 of the instruction.
- R8: Clear (0x28/0x29) yields 0x00 and set (0x2A/0x2B) yields 0xFF. Both always write the file register, and also write W when bit 8 (s) is 0. Move-W-to-file (0x01) writes W to the file register. None of these writes a flag.
- R9: Compare-and-skip (0x31 equal, 0x32 f>W, 0x30 f<W, unsigned) writes nothing and requests a skip when its relation holds.
- R10: Decrement-skip-if-zero (0x16/0x17), decrement-skip-if-nonzero (0x26/0x27), increment-skip-if-zero (0x1E/0x1F) and increment-skip-if-nonzero (0x24/0x25) write their result to the d destination. They write no flag and request a skip on the stated test of the result.
- R11: `skipReq` lasts one cycle. The next valid instruction, even after idle cycles, produces no write, no skip and no `unsupported`, and the instruction after it executes normally.
- R12: The word 0x0000 is a no-operation. Every other encoding not listed above raises `unsupported` and produces no write and no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| fileRdData | input | 8 | File register value at `fileAddr` |
| wregIn | input | 8 | Current W value |
| flagsIn | input | 4 | Current flags {OV,Z,DC,C} |
| fileAddr | output | 8 | File register address |
| fileWe | output | 1 | File register write enable |
| fileWrData | output | 8 | File register write data |
| wregWe | output | 1 | W write enable |
| wregWrData | output | 8 | W write data |
| flagWe | output | 4 | Per-flag write enables |
| flagWrData | output | 4 | New flag values |
| skipReq | output | 1 | Discard the next instruction |
| unsupported | output | 1 | Encoding not handled |

## Verification
A stuck or missed squash bit shows up in the cycle right after a skip. Either the discarded instruction produces writes, or a normal instruction is silently lost and its expected writes never appear. A decode error changes the enables or the flag mask in the same cycle the opcode is presented, because the stage is combinational apart from that one bit. The bench sweeps every upper-byte value against a grid of operand and carry values, so every opcode's flag set and destination is compared at each issue.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

  localparam int FLAG_C  = 0;
  localparam int FLAG_DC = 1;
  localparam int FLAG_Z  = 2;
  localparam int FLAG_OV = 3;
  localparam int FLAG_N  = 4;

  typedef enum logic [3:0] {
    OP_ADD, OP_AND, OP_IOR, OP_COM, OP_RLC, OP_RLNC,
    OP_RRC, OP_RRNC, OP_SWAP, OP_CLR, OP_SET, OP_PASSW
  } aluOpE;

  typedef enum logic [1:0] { B_W, B_NOTW, B_ZERO, B_ONES } bSelE;

  typedef enum logic [1:0] { CI_ZERO, CI_ONE, CI_FLAG } cinSelE;

  typedef enum logic [2:0] {
    SK_NONE, SK_ZERO, SK_NZERO, SK_EQ, SK_GT, SK_LT
  } skipE;

  typedef struct packed {
    aluOpE              aluOp;
    bSelE               bSel;
    cinSelE             cinSel;
    logic               wrW;
    logic               wrF;
    logic [FLAG_N-1:0]  flagMask;
    skipE               skipCond;
    logic               unsup;
  } strobeT;

endpackage

// File: rtl/regalu_ctrl.sv
module regalu_ctrl
  import regalu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [7:0]        opHi,
  input  logic [ADDR_W-1:0] opLo,
  input  logic              skipHit,
  output strobeT            strobe,
  output logic              skipReq,
  output logic              unsupported
);

  localparam logic [FLAG_N-1:0] MASK_ALL  = '1;
  localparam logic [FLAG_N-1:0] MASK_Z    = FLAG_N'(1) << FLAG_Z;
  localparam logic [FLAG_N-1:0] MASK_C    = FLAG_N'(1) << FLAG_C;
  localparam logic [FLAG_N-1:0] MASK_NONE = '0;

  strobeT dec;
  logic   useD;
  logic   squash;
  logic   active;

  always_comb begin
    dec = '{aluOp: OP_ADD, bSel: B_W, cinSel: CI_ZERO, wrW: 1'b0, wrF: 1'b0,
            flagMask: MASK_NONE, skipCond: SK_NONE, unsup: 1'b1};
    useD = 1'b0;
    case (opHi)
      8'h00: dec.unsup = (opLo != '0);
      8'h01: begin dec.aluOp = OP_PASSW; dec.wrF = 1'b1; dec.unsup = 1'b0; end
      8'h0E, 8'h0F: begin dec.flagMask = MASK_ALL; useD = 1'b1; end
      8'h10, 8'h11: begin dec.cinSel = CI_FLAG; dec.flagMask = MASK_ALL; useD = 1'b1; end
      8'h04, 8'h05: begin
        dec.bSel = B_NOTW; dec.cinSel = CI_ONE; dec.flagMask = MASK_ALL; useD = 1'b1;
      end
      8'h02, 8'h03: begin
        dec.bSel = B_NOTW; dec.cinSel = CI_FLAG; dec.flagMask = MASK_ALL; useD = 1'b1;
      end
      8'h14, 8'h15: begin
        dec.bSel = B_ZERO; dec.cinSel = CI_ONE; dec.flagMask = MASK_ALL; useD = 1'b1;
      end
      8'h06, 8'h07: begin dec.bSel = B_ONES; dec.flagMask = MASK_ALL; useD = 1'b1; end
      8'h0A, 8'h0B: begin dec.aluOp = OP_AND; dec.flagMask = MASK_Z; useD = 1'b1; end
      8'h08, 8'h09: begin dec.aluOp = OP_IOR; dec.flagMask = MASK_Z; useD = 1'b1; end
      8'h12, 8'h13: begin dec.aluOp = OP_COM; dec.flagMask = MASK_Z; useD = 1'b1; end
      8'h1A, 8'h1B: begin dec.aluOp = OP_RLC; dec.flagMask = MASK_C; useD = 1'b1; end
      8'h18, 8'h19: begin dec.aluOp = OP_RRC; dec.flagMask = MASK_C; useD = 1'b1; end
      8'h22, 8'h23: begin dec.aluOp = OP_RLNC; useD = 1'b1; end
      8'h20, 8'h21: begin dec.aluOp = OP_RRNC; useD = 1'b1; end
      8'h1C, 8'h1D: begin dec.aluOp = OP_SWAP; useD = 1'b1; end
      8'h16, 8'h17: begin dec.bSel = B_ONES; dec.skipCond = SK_ZERO; useD = 1'b1; end
      8'h26, 8'h27: begin dec.bSel = B_ONES; dec.skipCond = SK_NZERO; useD = 1'b1; end
      8'h1E, 8'h1F: begin
        dec.bSel = B_ZERO; dec.cinSel = CI_ONE; dec.skipCond = SK_ZERO; useD = 1'b1;
      end
      8'h24, 8'h25: begin
        dec.bSel = B_ZERO; dec.cinSel = CI_ONE; dec.skipCond = SK_NZERO; useD = 1'b1;
      end
      8'h28, 8'h29: begin
        dec.aluOp = OP_CLR; dec.wrF = 1'b1; dec.wrW = ~opHi[0]; dec.unsup = 1'b0;
      end
      8'h2A, 8'h2B: begin
        dec.aluOp = OP_SET; dec.wrF = 1'b1; dec.wrW = ~opHi[0]; dec.unsup = 1'b0;
      end
      8'h31: begin dec.skipCond = SK_EQ; dec.unsup = 1'b0; end
      8'h32: begin dec.skipCond = SK_GT; dec.unsup = 1'b0; end
      8'h30: begin dec.skipCond = SK_LT; dec.unsup = 1'b0; end
      default: dec.unsup = 1'b1;
    endcase
    if (useD) begin
      dec.wrF   = opHi[0];
      dec.wrW   = ~opHi[0];
      dec.unsup = 1'b0;
    end
  end

  assign active = instrValid && !squash;

  always_comb begin
    strobe          = dec;
    strobe.wrW      = dec.wrW && active;
    strobe.wrF      = dec.wrF && active;
    strobe.flagMask = active ? dec.flagMask : MASK_NONE;
    strobe.skipCond = active ? dec.skipCond : SK_NONE;
    strobe.unsup    = dec.unsup && active;
  end

  assign skipReq     = active && skipHit;
  assign unsupported = strobe.unsup;

  always_ff @(posedge clk) begin
    if (!rstN)           squash <= 1'b0;
    else if (instrValid) squash <= skipReq;
  end

  AST_SKIP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |=> !skipReq); // R11

endmodule

// File: rtl/regalu_dp.sv
module regalu_dp
  import regalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] fileRd,
  input  logic [DATA_W-1:0] wreg,
  input  logic [FLAG_N-1:0] flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] flagsNew,
  output logic              skipHit
);

  localparam int NIB = DATA_W / 2;
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bOp;
  logic              cin;
  logic [DATA_W:0]   sumW;
  logic [NIB:0]      sumLo;
  logic              ovf;

  always_comb begin
    case (strobe.bSel)
      B_W:     bOp = wreg;
      B_NOTW:  bOp = ~wreg;
      B_ZERO:  bOp = '0;
      default: bOp = '1;
    endcase
    case (strobe.cinSel)
      CI_ONE:  cin = 1'b1;
      CI_FLAG: cin = flagsIn[FLAG_C];
      default: cin = 1'b0;
    endcase
  end

  assign sumW  = {1'b0, fileRd} + {1'b0, bOp} + {{DATA_W{1'b0}}, cin};
  assign sumLo = {1'b0, fileRd[NIB-1:0]} + {1'b0, bOp[NIB-1:0]} + {{NIB{1'b0}}, cin};
  assign ovf   = (fileRd[MSB] == bOp[MSB]) && (sumW[MSB] != fileRd[MSB]);

  always_comb begin
    case (strobe.aluOp)
      OP_AND:   result = fileRd & wreg;
      OP_IOR:   result = fileRd | wreg;
      OP_COM:   result = ~fileRd;
      OP_RLC:   result = {fileRd[MSB-1:0], flagsIn[FLAG_C]};
      OP_RLNC:  result = {fileRd[MSB-1:0], fileRd[MSB]};
      OP_RRC:   result = {flagsIn[FLAG_C], fileRd[MSB:1]};
      OP_RRNC:  result = {fileRd[0], fileRd[MSB:1]};
      OP_SWAP:  result = {fileRd[NIB-1:0], fileRd[MSB:NIB]};
      OP_CLR:   result = '0;
      OP_SET:   result = '1;
      OP_PASSW: result = wreg;
      default:  result = sumW[DATA_W-1:0];
    endcase
  end

  always_comb begin
    flagsNew          = flagsIn;
    flagsNew[FLAG_Z]  = (result == '0);
    flagsNew[FLAG_DC] = sumLo[NIB];
    flagsNew[FLAG_OV] = ovf;
    case (strobe.aluOp)
      OP_RLC:  flagsNew[FLAG_C] = fileRd[MSB];
      OP_RRC:  flagsNew[FLAG_C] = fileRd[0];
      default: flagsNew[FLAG_C] = sumW[DATA_W];
    endcase
  end

  always_comb begin
    case (strobe.skipCond)
      SK_ZERO:  skipHit = (result == '0);
      SK_NZERO: skipHit = (result != '0);
      SK_EQ:    skipHit = (fileRd == wreg);
      SK_GT:    skipHit = (fileRd > wreg);
      SK_LT:    skipHit = (fileRd < wreg);
      default:  skipHit = 1'b0;
    endcase
  end

endmodule

// File: rtl/regalu_exec.sv
module regalu_exec
  import regalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instrValid,
  input  logic [8+ADDR_W-1:0] instr,
  input  logic [DATA_W-1:0]   fileRdData,
  input  logic [DATA_W-1:0]   wregIn,
  input  logic [FLAG_N-1:0]   flagsIn,
  output logic [ADDR_W-1:0]   fileAddr,
  output logic                fileWe,
  output logic [DATA_W-1:0]   fileWrData,
  output logic                wregWe,
  output logic [DATA_W-1:0]   wregWrData,
  output logic [FLAG_N-1:0]   flagWe,
  output logic [FLAG_N-1:0]   flagWrData,
  output logic                skipReq,
  output logic                unsupported
);

  localparam int INSTR_W = 8 + ADDR_W;

  strobeT            strobe;
  logic              skipHit;
  logic [DATA_W-1:0] result;

  regalu_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .instrValid  (instrValid),
    .opHi        (instr[INSTR_W-1:ADDR_W]),
    .opLo        (instr[ADDR_W-1:0]),
    .skipHit     (skipHit),
    .strobe      (strobe),
    .skipReq     (skipReq),
    .unsupported (unsupported)
  );

  regalu_dp #(.DATA_W(DATA_W)) uDp (
    .strobe   (strobe),
    .fileRd   (fileRdData),
    .wreg     (wregIn),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsNew (flagWrData),
    .skipHit  (skipHit)
  );

  assign fileAddr   = instr[ADDR_W-1:0];
  assign fileWe     = strobe.wrF;
  assign wregWe     = strobe.wrW;
  assign fileWrData = result;
  assign wregWrData = result;
  assign flagWe     = strobe.flagMask;

  AST_SQUASH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |=> (!fileWe && !wregWe && flagWe == '0 && !unsupported)); // R11
  AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> (!fileWe && !wregWe && flagWe == '0 && !skipReq)); // R12
  AST_SKIP_EQ: assert property (@(posedge clk) disable iff (!rstN)
    (skipReq && instr[INSTR_W-1:ADDR_W] == 8'h31) |-> (fileRdData == wregIn)); // R9
  AST_SKIP_NOFLAG: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |-> (flagWe == '0)); // R10

endmodule

// File: tb/sim_regalu_exec.sv
module sim_regalu_exec;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  fileRd = '0;
  logic [7:0]  wreg = '0;
  logic [3:0]  flags = '0;
  logic [7:0]  fileAddr;
  logic        fileWe;
  logic [7:0]  fileWrData;
  logic        wregWe;
  logic [7:0]  wregWrData;
  logic [3:0]  flagWe;
  logic [3:0]  flagWrData;
  logic        skipReq;
  logic        unsupported;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regalu_exec u0 (
    .clk(clk), .rstN(rstN), .instrValid(valid), .instr(instr),
    .fileRdData(fileRd), .wregIn(wreg), .flagsIn(flags),
    .fileAddr(fileAddr), .fileWe(fileWe), .fileWrData(fileWrData),
    .wregWe(wregWe), .wregWrData(wregWrData), .flagWe(flagWe),
    .flagWrData(flagWrData), .skipReq(skipReq), .unsupported(unsupported)
  );

  // expected values
  logic       eFW, eWW, eSk, eUn;
  logic [7:0] eRes;
  logic [3:0] eFm, eFl;
  string      eTag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (instr %h f %h w %h c %b)",
               tag, what, act, exp, instr, fileRd, wreg, flags[0]);
    end
  endtask

  function automatic int sgn(input logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  task automatic addModel(input logic [7:0] a, input logic [7:0] b, input int c);
    int u = int'(a) + int'(b) + c;
    int s = sgn(a) + sgn(b) + c;
    eRes = u[7:0];
    eFl[0] = (u > 255);
    eFl[1] = (int'(a[3:0]) + int'(b[3:0]) + c) > 15;
    eFl[2] = (eRes == 0);
    eFl[3] = (s > 127) || (s < -128);
  endtask

  task automatic subModel(input logic [7:0] a, input logic [7:0] b, input int c);
    int u = int'(a) - int'(b) - (1 - c);
    int s = sgn(a) - sgn(b) - (1 - c);
    eRes = u[7:0];
    eFl[0] = (u >= 0);
    eFl[1] = (int'(a[3:0]) - int'(b[3:0]) - (1 - c)) >= 0;
    eFl[2] = (eRes == 0);
    eFl[3] = (s > 127) || (s < -128);
  endtask

  task automatic model(input logic [15:0] ins, input logic [7:0] f,
                       input logic [7:0] w, input logic [3:0] fl);
    logic [7:0] hi = ins[15:8];
    logic       d  = hi[0];
    int         c  = int'(fl[0]);
    bit         dform = 1'b1;
    eFW = 0; eWW = 0; eSk = 0; eUn = 0; eRes = '0; eFm = '0; eFl = '0; eTag = "R7";
    case (hi)
      8'h0E, 8'h0F: begin addModel(f, w, 0); eFm = 4'hF; eTag = "R2"; end
      8'h10, 8'h11: begin addModel(f, w, c); eFm = 4'hF; eTag = "R2"; end
      8'h04, 8'h05: begin subModel(f, w, 1); eFm = 4'hF; eTag = "R3"; end
      8'h02, 8'h03: begin subModel(f, w, c); eFm = 4'hF; eTag = "R3"; end
      8'h14, 8'h15: begin addModel(f, 8'h00, 1); eFm = 4'hF; eTag = "R4"; end
      8'h06, 8'h07: begin subModel(f, 8'h01, 1); eFm = 4'hF; eTag = "R4"; end
      8'h0A, 8'h0B: begin eRes = f & w; eFm = 4'b0100; eFl[2] = (eRes == 0); eTag = "R5"; end
      8'h08, 8'h09: begin eRes = f | w; eFm = 4'b0100; eFl[2] = (eRes == 0); eTag = "R5"; end
      8'h12, 8'h13: begin eRes = ~f; eFm = 4'b0100; eFl[2] = (eRes == 0); eTag = "R5"; end
      8'h1A, 8'h1B: begin eRes = {f[6:0], fl[0]}; eFm = 4'b0001; eFl[0] = f[7]; eTag = "R6"; end
      8'h18, 8'h19: begin eRes = {fl[0], f[7:1]}; eFm = 4'b0001; eFl[0] = f[0]; eTag = "R6"; end
      8'h22, 8'h23: begin eRes = {f[6:0], f[7]}; eTag = "R6"; end
      8'h20, 8'h21: begin eRes = {f[0], f[7:1]}; eTag = "R6"; end
      8'h1C, 8'h1D: begin eRes = {f[3:0], f[7:4]}; eTag = "R6"; end
      8'h16, 8'h17: begin eRes = f - 8'd1; eSk = (eRes == 0); eTag = "R10"; end
      8'h26, 8'h27: begin eRes = f - 8'd1; eSk = (eRes != 0); eTag = "R10"; end
      8'h1E, 8'h1F: begin eRes = f + 8'd1; eSk = (eRes == 0); eTag = "R10"; end
      8'h24, 8'h25: begin eRes = f + 8'd1; eSk = (eRes != 0); eTag = "R10"; end
      default: begin
        dform = 1'b0;
        eTag = "R12";
        case (hi)
          8'h28, 8'h29: begin eRes = 8'h00; eFW = 1; eWW = !hi[0]; eTag = "R8"; end
          8'h2A, 8'h2B: begin eRes = 8'hFF; eFW = 1; eWW = !hi[0]; eTag = "R8"; end
          8'h01: begin eRes = w; eFW = 1; eTag = "R8"; end
          8'h31: begin eSk = (f == w); eTag = "R9"; end
          8'h32: begin eSk = (f > w); eTag = "R9"; end
          8'h30: begin eSk = (f < w); eTag = "R9"; end
          8'h00: eUn = (ins[7:0] != 0);
          default: eUn = 1;
        endcase
      end
    endcase
    if (dform) begin eFW = d; eWW = !d; end
  endtask

  task automatic compareAll();
    chk(fileAddr == instr[7:0], "R7", "fileAddr", fileAddr, instr[7:0]);
    chk(fileWe == eFW, eTag, "fileWe", fileWe, eFW);
    chk(wregWe == eWW, eTag, "wregWe", wregWe, eWW);
    if (eFW) chk(fileWrData == eRes, eTag, "fileWrData", fileWrData, eRes);
    if (eWW) chk(wregWrData == eRes, eTag, "wregWrData", wregWrData, eRes);
    chk(flagWe == eFm, eTag, "flagWe", flagWe, eFm);
    chk((flagWrData & eFm) == (eFl & eFm), eTag, "flagWrData",
        flagWrData & eFm, eFl & eFm);
    chk(skipReq == eSk, eTag, "skipReq", skipReq, eSk);
    chk(unsupported == eUn, eTag, "unsupported", unsupported, eUn);
  endtask

  task automatic issue(input logic [15:0] ins, input logic [7:0] f,
                       input logic [7:0] w, input logic [3:0] fl);
    @(negedge clk);
    instr = ins; fileRd = f; wreg = w; flags = fl; valid = 1'b1;
    #1;
    model(ins, f, w, fl);
    compareAll();
  endtask

  task automatic quietCheck(input string tag, input bit v);
    @(negedge clk);
    valid = v; instr = 16'h0F3C; fileRd = 8'h11; wreg = 8'h22;
    #1;
    chk(!fileWe && !wregWe, tag, "writes", {fileWe, wregWe}, 0);
    chk(flagWe == 0, tag, "flagWe", flagWe, 0);
    chk(!skipReq && !unsupported, tag, "skip/unsup", {skipReq, unsupported}, 0);
  endtask

  localparam logic [7:0] VALS [9] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F,
                                      8'h80, 8'hFF, 8'h5A, 8'hA5};

  initial begin
    // R1: idle during and after reset
    repeat (3) @(posedge clk);
    #1;
    chk(!fileWe && !wregWe && flagWe == 0 && !skipReq && !unsupported,
        "R1", "idle in reset", 0, 0);
    @(negedge clk); rstN = 1'b1;
    quietCheck("R1", 1'b0);
    issue(16'h0F20, 8'h01, 8'h02, 4'h0);              // R1: first op executes
    // R1: reset drops a pending squash
    issue(16'h3100, 8'h44, 8'h44, 4'h0);
    @(negedge clk); valid = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    issue(16'h0F12, 8'h01, 8'h02, 4'h0);
    chk(fileWe == 1'b1, "R1", "exec after reset", fileWe, 1);
    // R11: squash survives idle cycles
    issue(16'h3100, 8'h05, 8'h05, 4'h0);
    for (int k = 0; k < 3; k++) quietCheck("R11", 1'b0);
    quietCheck("R11", 1'b1);
    issue(16'h0E00, 8'h01, 8'h02, 4'h0);              // R11: resumes
    chk(wregWe == 1'b1, "R11", "resume", wregWe, 1);
    // Near-exhaustive sweep over opcode byte, operands and carry
    for (int op = 0; op < 256; op++) begin
      for (int i = 0; i < 9; i++) begin
        for (int j = 0; j < 9; j++) begin
          for (int cc = 0; cc < 2; cc++) begin
            issue({op[7:0], 8'(i * 9 + j)}, VALS[i], VALS[j], {3'b101, cc[0]});
            if (eSk) quietCheck("R11", 1'b1);
          end
        end
      end
    end
    @(negedge clk); valid = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule